// File: doc/BRIEF.md
# Ten-Bit Address Read Sequencer

This block sequences the commands of an I2C master. It turns one command at a time into requests for a byte-level bus engine. The engine handles the bit timing and reports back once per request. Each command carries a slave address, a 10-bit flag, a same-address flag, a direction bit, a start flag, a stop flag and a byte count. The block turns this into start or repeated-start conditions, address bytes, data bytes and a stop. It raises a one-cycle completion pulse at the end of every command.

Reading from a 10-bit slave takes two chained commands. The first is a write-direction address phase with a start, no stop and zero data bytes. The address is sent as a header byte that holds the 11110 pattern, address bits 9:8 and a cleared R/W bit. The low eight address bits follow once the header is acknowledged. The bus stays held after this command. A second command, queued in a one-entry next-command slot, then runs automatically. It has the same-address flag set. It gives a repeated start, a header with R/W set and no low address byte, then the data bytes and a stop.

Software writes the active command through one strobe and the queued command through another. Received bytes leave through a one-cycle valid pulse. Two status flags report errors: one for an address NACK and one for an illegal command.

Top module: `tenrd_seq`

## Requirements
- R1: An engine request uses `eng_op` with START=1, RSTART=2, TX=3, RX=4 and STOP=5. A 7-bit address phase sends one TX byte `{addr[6:0], rw}` after the start. A start is a START when the bus is free and an RSTART when a previous command left the bus held.
- R2: A 10-bit address phase whose same-address flag is clear sends the header `{5'b11110, addr[9:8], 1'b0}`. After the header's ACK it sends `addr[7:0]`. Bits 9:8 are recorded for later reuse.
- R3: A command that ends without a stop leaves the bus held. If the next-command slot is full at that point, its contents become the active command and the slot empties. The chained command runs once, and its start is issued as RSTART.
- R4: A command with the same-address flag set sends only `{5'b11110, recorded addr[9:8], 1'b1}` after its start. No low address byte follows.
- R5: In a read, each byte returned by the engine appears on `rx_data` with a one-cycle `rx_valid` pulse. `eng_mack` is 1 (ACK) for every RX request except the last, where it is 0 (NACK).
- R6: In a write, every data byte sends the value on `wr_data`, and `wr_pop` pulses once as each byte completes.
- R7: A NACK on any address byte ends the command with a STOP and sets `addr_nack`. It also empties the next-command slot and clears the recorded 10-bit address.
- R8: A command is rejected with `cmd_err` set and no engine request in two cases. The first is a command with the same-address flag set while no 10-bit address is recorded. The second is a read with the 10-bit flag set and the same-address flag clear.
- R9: A `cmd_wr` strobe that arrives while a command is in progress is ignored.
- R10: `done` pulses for exactly one cycle at the end of each executed command, aborted commands included. The status flags clear when the next command is accepted.
- R11: After reset, `eng_req`, `busy`, `rx_valid`, `addr_nack` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Load the command fields into the active slot |
| ncmd_wr | input | 1 | Load the command fields into the next-command slot |
| cmd_addr | input | 10 | Slave address (bits 6:0 used in 7-bit mode) |
| cmd_tenbit | input | 1 | Use a 10-bit address |
| cmd_repsame | input | 1 | Reuse the recorded 10-bit address, header only |
| cmd_read | input | 1 | Read direction |
| cmd_start | input | 1 | Issue a start and an address phase |
| cmd_stop | input | 1 | End the command with a stop |
| cmd_nbytes | input | NB_W | Number of data bytes |
| wr_data | input | 8 | Byte to transmit in a write data phase |
| wr_pop | output | 1 | A write data byte has completed |
| eng_req | output | 1 | Request pending to the byte engine |
| eng_op | output | 3 | Requested operation |
| eng_txdata | output | 8 | Byte to transmit |
| eng_mack | output | 1 | ACK (1) or NACK (0) to send after an RX byte |
| eng_done | input | 1 | Engine finished the current request |
| eng_nack | input | 1 | Slave NACKed the transmitted byte |
| eng_rxdata | input | 8 | Byte received by the engine |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command completion pulse |
| addr_nack | output | 1 | Last command aborted on an address NACK |
| cmd_err | output | 1 | Last command rejected as illegal |

## Verification
The assertions cover the cycle-level rules on every cycle. A request holds its operation until the engine answers. An address NACK leads straight to a stop and sets the flag. A same-address header is never followed by a low address byte. The byte counter never underflows. A rejected command leaves the engine idle. A strobe during a busy command leaves the active slot unchanged. A chained load empties the slot. Only the bench's scenarios show the byte values on the bus, the START versus RSTART choice, the ACK pattern, and the completion counts. They also show that an abort drops the queued command and that a later same-address command is rejected.

// File: rtl/tenrd_pkg.sv
package tenrd_pkg;

    localparam int ADDR_W = 10;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_TX     = 3'd3,
        OP_RX     = 3'd4,
        OP_STOP   = 3'd5
    } eng_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COND,
        S_HDR,
        S_LOW,
        S_DATA,
        S_STOP,
        S_FIN
    } seq_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              tenbit;
        logic              repsame;
        logic              read;
        logic              start;
        logic              stop;
    } cmd_t;

    localparam logic [4:0] TEN_MARK = 5'b11110;

    function automatic logic [7:0] hdr10(input logic [1:0] hi, input logic rw);
        return {TEN_MARK, hi, rw};
    endfunction

    function automatic logic [7:0] addr7(input logic [6:0] a, input logic rw);
        return {a, rw};
    endfunction

    // illegal: header reuse with nothing recorded, or full 10-bit phase in read direction
    function automatic logic cmd_bad(input cmd_t c, input logic have10);
        return (c.repsame && !have10) || (c.tenbit && !c.repsame && c.read);
    endfunction

endpackage

// File: rtl/tenrd_slots.sv
module tenrd_slots
    import tenrd_pkg::*;
#(
    parameter int NB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_t            wr_cmd,
    input  logic [NB_W-1:0] wr_nb,
    input  logic            cmd_wr,
    input  logic            ncmd_wr,
    input  logic            busy,
    input  logic            take,
    input  logic            chain,
    input  logic            flush,
    output cmd_t            act,
    output logic [NB_W-1:0] act_nb,
    output logic            act_valid
);

    cmd_t            nxt;
    logic [NB_W-1:0] nxt_nb;
    logic            nxt_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= '0;
            act_nb    <= '0;
            act_valid <= 1'b0;
            nxt       <= '0;
            nxt_nb    <= '0;
            nxt_valid <= 1'b0;
        end else begin
            if (take) begin
                act_valid <= 1'b0;
            end
            if (cmd_wr && !busy && !act_valid) begin
                act       <= wr_cmd;
                act_nb    <= wr_nb;
                act_valid <= 1'b1;
            end
            if (chain && nxt_valid) begin
                act       <= nxt;
                act_nb    <= nxt_nb;
                act_valid <= 1'b1;
                nxt_valid <= 1'b0;
            end
            if (flush) begin
                nxt_valid <= 1'b0;
            end
            if (ncmd_wr) begin
                nxt       <= wr_cmd;
                nxt_nb    <= wr_nb;
                nxt_valid <= 1'b1;
            end
        end
    end

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy && !chain) |=> ($stable(act) && $stable(act_nb)));

    assert_slot_once_R3: assert property (@(posedge clk) disable iff (rst)
        (chain && nxt_valid && !ncmd_wr) |=> (!nxt_valid && act_valid));

endmodule

// File: rtl/tenrd_bytecnt.sv
module tenrd_bytecnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ld_val;
        end else if (dec) begin
            cnt <= cnt - W'(1);
        end
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == W'(1));

    assert_cnt_floor_R5: assert property (@(posedge clk) disable iff (rst)
        dec |-> !is_zero);

endmodule

// File: rtl/tenrd_fsm.sv
module tenrd_fsm
    import tenrd_pkg::*;
#(
    parameter int NB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_t            act,
    input  logic [NB_W-1:0] act_nb,
    input  logic            act_valid,
    input  logic            cnt_zero,
    input  logic            cnt_one,
    output logic            cnt_load,
    output logic            cnt_dec,
    output logic            take,
    output logic            chain,
    output logic            flush,
    output logic            busy,
    input  logic [7:0]      wr_data,
    output logic            wr_pop,
    output logic            eng_req,
    output logic [2:0]      eng_op,
    output logic [7:0]      eng_txdata,
    output logic            eng_mack,
    input  logic            eng_done,
    input  logic            eng_nack,
    input  logic [7:0]      eng_rxdata,
    output logic            rx_valid,
    output logic [7:0]      rx_data,
    output logic            done,
    output logic            addr_nack,
    output logic            cmd_err
);

    seq_st_e    st;
    seq_st_e    nxt_after;
    cmd_t       cur;
    logic       bus_held;
    logic       have10;
    logic [1:0] last_hi;
    logic       aborted;
    logic       bad;
    logic [7:0] hdr_byte;
    eng_op_e    op;

    assign bad      = cmd_bad(act, have10);
    assign take     = (st == S_IDLE) && act_valid;
    assign cnt_load = take && !bad;
    assign cnt_dec  = (st == S_DATA) && eng_done;

    always_comb begin
        if (!cnt_zero)     nxt_after = S_DATA;
        else if (cur.stop) nxt_after = S_STOP;
        else               nxt_after = S_FIN;
    end

    always_comb begin
        if (cur.repsame)     hdr_byte = hdr10(last_hi, 1'b1);
        else if (cur.tenbit) hdr_byte = hdr10(cur.addr[9:8], 1'b0);
        else                 hdr_byte = addr7(cur.addr[6:0], cur.read);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cur       <= '0;
            bus_held  <= 1'b0;
            have10    <= 1'b0;
            last_hi   <= 2'b00;
            aborted   <= 1'b0;
            addr_nack <= 1'b0;
            cmd_err   <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= 8'h00;
        end else begin
            rx_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (act_valid) begin
                        cur       <= act;
                        aborted   <= 1'b0;
                        addr_nack <= 1'b0;
                        cmd_err   <= bad;
                        if (!bad) begin
                            if (act.start)          st <= S_COND;
                            else if (act_nb != '0)  st <= S_DATA;
                            else if (act.stop)      st <= S_STOP;
                            else                    st <= S_FIN;
                        end
                    end
                end
                S_COND: begin
                    if (eng_done) begin
                        bus_held <= 1'b1;
                        st       <= S_HDR;
                    end
                end
                S_HDR: begin
                    if (eng_done) begin
                        if (eng_nack) begin
                            addr_nack <= 1'b1;
                            aborted   <= 1'b1;
                            have10    <= 1'b0;
                            st        <= S_STOP;
                        end else if (cur.tenbit && !cur.repsame) begin
                            st <= S_LOW;
                        end else begin
                            st <= nxt_after;
                        end
                    end
                end
                S_LOW: begin
                    if (eng_done) begin
                        if (eng_nack) begin
                            addr_nack <= 1'b1;
                            aborted   <= 1'b1;
                            have10    <= 1'b0;
                            st        <= S_STOP;
                        end else begin
                            have10  <= 1'b1;
                            last_hi <= cur.addr[9:8];
                            st      <= nxt_after;
                        end
                    end
                end
                S_DATA: begin
                    if (eng_done) begin
                        if (cur.read) begin
                            rx_valid <= 1'b1;
                            rx_data  <= eng_rxdata;
                        end
                        if (cnt_one) st <= cur.stop ? S_STOP : S_FIN;
                    end
                end
                S_STOP: begin
                    if (eng_done) begin
                        bus_held <= 1'b0;
                        st       <= S_FIN;
                    end
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        op         = OP_NONE;
        eng_txdata = 8'h00;
        case (st)
            S_COND: op = bus_held ? OP_RSTART : OP_START;
            S_HDR: begin
                op         = OP_TX;
                eng_txdata = hdr_byte;
            end
            S_LOW: begin
                op         = OP_TX;
                eng_txdata = cur.addr[7:0];
            end
            S_DATA: begin
                op         = cur.read ? OP_RX : OP_TX;
                eng_txdata = cur.read ? 8'h00 : wr_data;
            end
            S_STOP:  op = OP_STOP;
            default: op = OP_NONE;
        endcase
    end

    assign eng_op   = op;
    assign eng_req  = (op != OP_NONE);
    assign eng_mack = (st == S_DATA) && cur.read && !cnt_one;
    assign wr_pop   = (st == S_DATA) && !cur.read && eng_done;
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_FIN);
    assign chain    = (st == S_FIN) && !cur.stop && !aborted;
    assign flush    = (st == S_FIN) && aborted;

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op)));

    assert_hdr_only_R4: assert property (@(posedge clk) disable iff (rst)
        ((st == S_HDR) && cur.repsame && eng_done && !eng_nack) |=> (st != S_LOW));

    assert_last_byte_end_R5: assert property (@(posedge clk) disable iff (rst)
        ((st == S_DATA) && eng_done && cnt_one) |=> ((st == S_STOP) || (st == S_FIN)));

    assert_abort_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (((st == S_HDR) || (st == S_LOW)) && eng_done && eng_nack) |=> ((st == S_STOP) && addr_nack));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_err) |-> ((st == S_IDLE) && !eng_req));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/tenrd_seq.sv
module tenrd_seq
    import tenrd_pkg::*;
#(
    parameter int NB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_wr,
    input  logic            ncmd_wr,
    input  logic [9:0]      cmd_addr,
    input  logic            cmd_tenbit,
    input  logic            cmd_repsame,
    input  logic            cmd_read,
    input  logic            cmd_start,
    input  logic            cmd_stop,
    input  logic [NB_W-1:0] cmd_nbytes,
    input  logic [7:0]      wr_data,
    output logic            wr_pop,
    output logic            eng_req,
    output logic [2:0]      eng_op,
    output logic [7:0]      eng_txdata,
    output logic            eng_mack,
    input  logic            eng_done,
    input  logic            eng_nack,
    input  logic [7:0]      eng_rxdata,
    output logic            rx_valid,
    output logic [7:0]      rx_data,
    output logic            busy,
    output logic            done,
    output logic            addr_nack,
    output logic            cmd_err
);

    cmd_t            wr_cmd;
    cmd_t            act;
    logic [NB_W-1:0] act_nb;
    logic            act_valid;
    logic            take, chain, flush;
    logic            cnt_load, cnt_dec, cnt_zero, cnt_one;

    assign wr_cmd = '{addr: cmd_addr, tenbit: cmd_tenbit, repsame: cmd_repsame,
                      read: cmd_read, start: cmd_start, stop: cmd_stop};

    tenrd_slots #(.NB_W(NB_W)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .wr_nb     (cmd_nbytes),
        .cmd_wr    (cmd_wr),
        .ncmd_wr   (ncmd_wr),
        .busy      (busy),
        .take      (take),
        .chain     (chain),
        .flush     (flush),
        .act       (act),
        .act_nb    (act_nb),
        .act_valid (act_valid)
    );

    tenrd_bytecnt #(.W(NB_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_load),
        .ld_val  (act_nb),
        .dec     (cnt_dec),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    tenrd_fsm #(.NB_W(NB_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .act_nb     (act_nb),
        .act_valid  (act_valid),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .take       (take),
        .chain      (chain),
        .flush      (flush),
        .busy       (busy),
        .wr_data    (wr_data),
        .wr_pop     (wr_pop),
        .eng_req    (eng_req),
        .eng_op     (eng_op),
        .eng_txdata (eng_txdata),
        .eng_mack   (eng_mack),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .eng_rxdata (eng_rxdata),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .done       (done),
        .addr_nack  (addr_nack),
        .cmd_err    (cmd_err)
    );

endmodule

// File: tb/tenrd_seq_tb.sv
module tenrd_seq_tb;

    localparam int NB_W = 8;
    localparam int OP_START = 1, OP_RSTART = 2, OP_TX = 3, OP_RX = 4, OP_STOP = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_wr = 1'b0, ncmd_wr = 1'b0;
    logic [9:0]      cmd_addr = '0;
    logic            cmd_tenbit = 1'b0, cmd_repsame = 1'b0, cmd_read = 1'b0;
    logic            cmd_start = 1'b0, cmd_stop = 1'b0;
    logic [NB_W-1:0] cmd_nbytes = '0;
    logic [7:0]      wr_data = 8'h3C;
    logic            wr_pop, eng_req, eng_mack, rx_valid, busy, done, addr_nack, cmd_err;
    logic [2:0]      eng_op;
    logic [7:0]      eng_txdata, rx_data;
    logic            eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]      eng_rxdata = 8'h00;

    always #5 clk = ~clk;

    tenrd_seq #(.NB_W(NB_W)) u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .ncmd_wr(ncmd_wr), .cmd_addr(cmd_addr),
        .cmd_tenbit(cmd_tenbit), .cmd_repsame(cmd_repsame), .cmd_read(cmd_read),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_nbytes(cmd_nbytes),
        .wr_data(wr_data), .wr_pop(wr_pop), .eng_req(eng_req), .eng_op(eng_op),
        .eng_txdata(eng_txdata), .eng_mack(eng_mack), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_rxdata(eng_rxdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .busy(busy), .done(done), .addr_nack(addr_nack),
        .cmd_err(cmd_err)
    );

    int n_chk = 0, n_fail = 0;
    int wcnt = 0, done_cnt = 0, pop_cnt = 0, rx_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] rx_seed = 8'h5A;
    logic [12:0] exp_q[$];   // {nack_resp, mack, op[2:0], data[7:0]}
    string       tag_q[$];
    logic [7:0]  rx_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_op(input int op, input logic [7:0] d, input bit mack, input bit nk, input string tag);
        exp_q.push_back({nk, mack, 3'(op), d});
        tag_q.push_back(tag);
    endtask

    task automatic put_cmd(input bit nxt, input logic [9:0] a, input bit tb, input bit rs,
                           input bit rd, input bit st, input bit sp, input int nb);
        @(negedge clk);
        cmd_addr = a; cmd_tenbit = tb; cmd_repsame = rs; cmd_read = rd;
        cmd_start = st; cmd_stop = sp; cmd_nbytes = NB_W'(nb);
        if (nxt) ncmd_wr = 1'b1; else cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; ncmd_wr = 1'b0;
    endtask

    task automatic wait_quiet();
        repeat (4) @(negedge clk);
        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // behavioural byte engine and per-clock comparison against the expected op list
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                chk(!(eng_req && !eng_done && exp_q.size() == 0), "R9 unexpected request", eng_op, 0);
                if (eng_done) begin
                    eng_done = 1'b0; eng_nack = 1'b0; wcnt = 0;
                end else if (eng_req) begin
                    wcnt++;
                    if (wcnt == 2) begin
                        if (exp_q.size() != 0) begin
                            logic [12:0] e;
                            string t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            chk(eng_op == e[10:8], t, eng_op, e[10:8]);
                            if (e[10:8] == 3'(OP_TX)) chk(eng_txdata == e[7:0], t, eng_txdata, e[7:0]);
                            if (e[10:8] == 3'(OP_RX)) chk(eng_mack == e[11], "R5 ack pattern", eng_mack, e[11]);
                            eng_nack = e[12];
                            if (e[10:8] == 3'(OP_RX)) begin
                                eng_rxdata = rx_seed;
                                rx_q.push_back(rx_seed);
                                rx_seed = rx_seed + 8'h1D;
                            end
                        end
                        eng_done = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (done) done_cnt++;
                if (wr_pop) pop_cnt++;
                if (rx_valid) begin
                    logic [7:0] ex;
                    rx_cnt++;
                    ex = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hxx;
                    chk(rx_data === ex, "R5 received byte", rx_data, ex);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int d0, p0, r0;
        repeat (3) @(negedge clk);
        chk(!eng_req && !busy && !rx_valid, "R11 reset outputs", {eng_req, busy, rx_valid}, 0);
        chk(!addr_nack && !cmd_err, "R11 reset flags", {addr_nack, cmd_err}, 0);
        rst = 1'b0;

        // same-address with nothing recorded
        d0 = done_cnt;
        put_cmd(0, 10'h000, 1, 1, 1, 1, 1, 2);
        wait_quiet();
        chk(cmd_err == 1'b1, "R8 reuse without record", cmd_err, 1);
        chk(done_cnt == d0, "R8 no completion", done_cnt - d0, 0);

        // two-command 10-bit read
        d0 = done_cnt; r0 = rx_cnt;
        expect_op(OP_START, 8'h00, 0, 0, "R1 start");
        expect_op(OP_TX, 8'hF4, 0, 0, "R2 header");
        expect_op(OP_TX, 8'hA5, 0, 0, "R2 low byte");
        expect_op(OP_RSTART, 8'h00, 0, 0, "R3 repeated start");
        expect_op(OP_TX, 8'hF5, 0, 0, "R4 read header");
        expect_op(OP_RX, 8'h00, 1, 0, "R5 rx");
        expect_op(OP_RX, 8'h00, 1, 0, "R5 rx");
        expect_op(OP_RX, 8'h00, 0, 0, "R5 rx last");
        expect_op(OP_STOP, 8'h00, 0, 0, "R5 stop");
        put_cmd(1, 10'h000, 1, 1, 1, 1, 1, 3);
        put_cmd(0, 10'h2A5, 1, 0, 0, 1, 0, 0);
        wait_quiet();
        chk(done_cnt - d0 == 2, "R10 two completions", done_cnt - d0, 2);
        chk(rx_cnt - r0 == 3, "R5 byte count", rx_cnt - r0, 3);
        chk(!cmd_err && !addr_nack, "R10 flags cleared", {cmd_err, addr_nack}, 0);

        // 7-bit write with a strobe while busy
        d0 = done_cnt; p0 = pop_cnt;
        expect_op(OP_START, 8'h00, 0, 0, "R1 start free bus");
        expect_op(OP_TX, 8'hAA, 0, 0, "R1 7-bit address");
        expect_op(OP_TX, 8'h3C, 0, 0, "R6 data");
        expect_op(OP_TX, 8'h3C, 0, 0, "R6 data");
        expect_op(OP_STOP, 8'h00, 0, 0, "R6 stop");
        put_cmd(0, 10'h055, 0, 0, 0, 1, 1, 2);
        repeat (4) @(negedge clk);
        put_cmd(0, 10'h011, 0, 0, 1, 1, 1, 1);
        wait_quiet();
        chk(pop_cnt - p0 == 2, "R6 pop count", pop_cnt - p0, 2);
        chk(done_cnt - d0 == 1, "R9 ignored strobe", done_cnt - d0, 1);

        // 7-bit single-byte read
        d0 = done_cnt;
        expect_op(OP_START, 8'h00, 0, 0, "R1 start");
        expect_op(OP_TX, 8'h27, 0, 0, "R1 7-bit read address");
        expect_op(OP_RX, 8'h00, 0, 0, "R5 single byte nack");
        expect_op(OP_STOP, 8'h00, 0, 0, "R5 stop");
        put_cmd(0, 10'h013, 0, 0, 1, 1, 1, 1);
        wait_quiet();
        chk(done_cnt - d0 == 1, "R10 one completion", done_cnt - d0, 1);

        // NACK on the low address byte, queued command dropped
        d0 = done_cnt;
        expect_op(OP_START, 8'h00, 0, 0, "R1 start");
        expect_op(OP_TX, 8'hF2, 0, 0, "R2 header");
        expect_op(OP_TX, 8'hFF, 0, 1, "R7 low byte nacked");
        expect_op(OP_STOP, 8'h00, 0, 0, "R7 abort stop");
        put_cmd(1, 10'h000, 1, 1, 1, 1, 1, 2);
        put_cmd(0, 10'h1FF, 1, 0, 0, 1, 0, 0);
        wait_quiet();
        chk(addr_nack == 1'b1, "R7 flag", addr_nack, 1);
        chk(done_cnt - d0 == 1, "R7 slot flushed", done_cnt - d0, 1);
        put_cmd(0, 10'h000, 1, 1, 1, 1, 1, 1);
        wait_quiet();
        chk(cmd_err == 1'b1, "R7 record cleared", cmd_err, 1);
        chk(addr_nack == 1'b0, "R10 nack flag cleared", addr_nack, 0);

        // bus held with no queued command, then header NACK
        d0 = done_cnt;
        expect_op(OP_START, 8'h00, 0, 0, "R1 start");
        expect_op(OP_TX, 8'hF6, 0, 0, "R2 header");
        expect_op(OP_TX, 8'hC1, 0, 0, "R2 low byte");
        put_cmd(0, 10'h3C1, 1, 0, 0, 1, 0, 0);
        wait_quiet();
        chk(done_cnt - d0 == 1 && busy == 1'b0, "R3 idle with bus held", done_cnt - d0, 1);
        expect_op(OP_RSTART, 8'h00, 0, 0, "R3 repeated start");
        expect_op(OP_TX, 8'hF7, 0, 1, "R4 header nacked");
        expect_op(OP_STOP, 8'h00, 0, 0, "R7 abort stop");
        put_cmd(0, 10'h000, 1, 1, 1, 1, 1, 1);
        wait_quiet();
        chk(addr_nack == 1'b1, "R7 header nack flag", addr_nack, 1);

        // full 10-bit phase in read direction
        put_cmd(0, 10'h155, 1, 0, 1, 1, 1, 1);
        wait_quiet();
        chk(cmd_err == 1'b1, "R8 read with full 10-bit", cmd_err, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule